// File: doc/BRIEF.md
# Latched Break-Before-Make Switch Selector

This block is the digital control core of a sixteen-input analog selector. It takes a binary channel address, three select qualifiers (an active-high enable, an active-high chip select and an active-low chip select) and a level-sensitive strobe. From these it drives the gate enables of a two-level switch tree. The first level has one cell per input, and each cell has two series gates and a shunt gate. The second level has one series switch per bank of cells. The block also drives a pull-down request for an open-drain "channel active" flag.

The address and the qualifiers are followed while the strobe is high and frozen while it is low, so a host can set up a selection on a shared bus and then let go of it. A change from one connected input to another always passes through a programmable number of clock cycles with every path open. When the qualifiers fail, the block opens every path at the next clock edge with no dead time. All outputs come from registered state, so a qualifying selection shows at the outputs one clock after it is seen.

Top module: `vmux_switch_ctl`

## Requirements
- R1: While `strobe_i` is high, the address and qualifier inputs reach the selection logic directly. A qualifying selection seen at a clock edge shows at the outputs right after that edge when no path was connected before it.
- R2: While `strobe_i` is low, the block keeps the address and qualifiers it held at the last edge with the strobe high. Changes on `addr_i`, `en_i`, `cs_i` and `cs_n_i` then leave the outputs unchanged.
- R3: A path can be connected only when `en_i`=1, `cs_i`=1 and `cs_n_i`=0 (as latched). Each of the other seven combinations leaves every path open.
- R4: Address value k (0 to N_CH-1) closes cell k. Cell k drives bit k of `ser_in_o`, `ser_out_o` and `shunt_o`, so address 0 is the first input and the all-ones address is the last.
- R5: Cells 0 to N_CH/BANKS-1 form bank 0, the next N_CH/BANKS cells form bank 1, and so on. Bit b of `bank_o` is 1 only when a cell of bank b is connected.
- R6: In every cell the two series gates are equal, and the shunt gate is their complement.
- R7: `act_sink_o` is 1 (flag pulled low) exactly when some cell is connected, and 0 (flag released) when none is.
- R8: When the latched address changes while a path is connected, every path opens at the next edge. All paths stay open for DEAD_CYC cycles, and then the new cell closes.
- R9: When the latched qualifiers fail, all paths open at the next edge, including during a dead-time gap. When the qualifiers pass again and no gap is running, the latest address connects one edge later.
- R10: While the synchronous reset `rst_i` is high, all series gates and bank switches open, all shunts close and the flag is released. The held selection is cleared to "no channel", so after reset with the strobe low nothing connects.
- R11: At most one cell and at most one bank switch are closed in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| strobe_i | input | 1 | Level-sensitive latch control: follow when high, hold when low |
| addr_i | input | AW | Binary channel address |
| en_i | input | 1 | Enable qualifier, active high |
| cs_i | input | 1 | Chip select, active high |
| cs_n_i | input | 1 | Chip select, active low |
| ser_in_o | output | N_CH | Input-side series gate of each cell (1 = closed) |
| ser_out_o | output | N_CH | Output-side series gate of each cell (1 = closed) |
| shunt_o | output | N_CH | Shunt gate of each cell (1 = closed) |
| bank_o | output | BANKS | Second-level bank series switches (1 = closed) |
| act_sink_o | output | 1 | Pull-down request for the open-drain active flag |

## Verification
The bench builds the block with its defaults: sixteen cells in two banks of eight, and a dead time of two cycles. This small size lets the bench sweep every address, which covers both banks and the boundary between them. It also tries all eight qualifier combinations and counts each cycle of the gap against an arithmetic model. The tests cover strobe pulses, changes within a bank and across the two banks, a disable arriving in the middle of a gap, and reset while a valid selection is held.

// File: rtl/vmux_pkg.sv
package vmux_pkg;

   typedef struct packed {
      logic en;
      logic cs;
      logic cs_n;
   } vmux_qual_t;

   function automatic logic vmux_qual_ok(input vmux_qual_t q);
      return q.en && q.cs && !q.cs_n;
   endfunction

endpackage

// File: rtl/vmux_ctl_latch.sv
module vmux_ctl_latch
   import vmux_pkg::*;
#(
   parameter int AW = 4
)(
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic          stb_i,
   input  logic [AW-1:0] addr_i,
   input  vmux_qual_t    qual_i,
   output logic [AW-1:0] eff_addr_o,
   output vmux_qual_t    eff_qual_o
);

   logic [AW-1:0] hold_addr;
   vmux_qual_t    hold_qual;

   // Transparent while the strobe is high, frozen while it is low
   always_comb begin
      eff_addr_o = stb_i ? addr_i : hold_addr;
      eff_qual_o = stb_i ? qual_i : hold_qual;
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         hold_addr <= '0;
         hold_qual <= '0;
      end else begin
         hold_addr <= eff_addr_o;
         hold_qual <= eff_qual_o;
      end
   end

   // R2
   hold_addr_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !stb_i |=> (stb_i || (eff_addr_o == $past(eff_addr_o) && eff_qual_o == $past(eff_qual_o))));

endmodule

// File: rtl/vmux_bbm_seq.sv
module vmux_bbm_seq #(
   parameter int AW       = 4,
   parameter int DEAD_CYC = 2
)(
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic          req_valid_i,
   input  logic [AW-1:0] req_addr_i,
   output logic          conn_o,
   output logic [AW-1:0] cur_addr_o
);

   localparam int DW = (DEAD_CYC < 2) ? 1 : $clog2(DEAD_CYC + 1);
   localparam logic [DW-1:0] GAP_LOAD = DW'(DEAD_CYC - 1);

   logic [DW-1:0] gap_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         conn_o     <= 1'b0;
         cur_addr_o <= '0;
         gap_q      <= '0;
      end else if (!req_valid_i) begin
         conn_o <= 1'b0;
         gap_q  <= '0;
      end else if (conn_o) begin
         if (cur_addr_o != req_addr_i) begin
            conn_o <= 1'b0;
            gap_q  <= GAP_LOAD;
         end
      end else if (gap_q != '0) begin
         gap_q <= gap_q - 1'b1;
      end else begin
         conn_o     <= 1'b1;
         cur_addr_o <= req_addr_i;
      end
   end

   // R8
   bbm_switch_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      conn_o |=> (!conn_o || $stable(cur_addr_o)));

   // R9
   drop_on_disable_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !req_valid_i |=> !conn_o);

   // R8
   gap_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (gap_q != '0) |=> !conn_o);

endmodule

// File: rtl/vmux_gate_drv.sv
module vmux_gate_drv #(
   parameter int N_CH  = 16,
   parameter int BANKS = 2
)(
   input  logic                     conn_i,
   input  logic [$clog2(N_CH)-1:0]  sel_i,
   output logic [N_CH-1:0]          ser_in_o,
   output logic [N_CH-1:0]          ser_out_o,
   output logic [N_CH-1:0]          shunt_o,
   output logic [BANKS-1:0]         bank_o
);

   localparam int AW = $clog2(N_CH);
   localparam int BW = (BANKS < 2) ? 1 : $clog2(BANKS);

   for (genvar c = 0; c < N_CH; c++) begin : g_cell
      logic hit;
      assign hit          = conn_i && (sel_i == AW'(c));
      assign ser_in_o[c]  = hit;
      assign ser_out_o[c] = hit;
      assign shunt_o[c]   = ~hit;
   end

   if (BANKS == 1) begin : g_one_bank
      assign bank_o[0] = conn_i;
   end else begin : g_multi_bank
      for (genvar b = 0; b < BANKS; b++) begin : g_bank
         assign bank_o[b] = conn_i && (sel_i[AW-1 -: BW] == BW'(b));
      end
   end

endmodule

// File: rtl/vmux_switch_ctl.sv
module vmux_switch_ctl
   import vmux_pkg::*;
#(
   parameter int N_CH     = 16,
   parameter int BANKS    = 2,
   parameter int DEAD_CYC = 2,
   localparam int AW      = $clog2(N_CH)
)(
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             strobe_i,
   input  logic [AW-1:0]    addr_i,
   input  logic             en_i,
   input  logic             cs_i,
   input  logic             cs_n_i,
   output logic [N_CH-1:0]  ser_in_o,
   output logic [N_CH-1:0]  ser_out_o,
   output logic [N_CH-1:0]  shunt_o,
   output logic [BANKS-1:0] bank_o,
   output logic             act_sink_o
);

   if (N_CH < 2 || (1 << AW) != N_CH) begin : g_bad_nch
      $error("vmux_switch_ctl: N_CH must be a power of two, at least 2");
   end
   if (BANKS < 1 || BANKS > N_CH || (N_CH % BANKS) != 0 ||
       (BANKS & (BANKS - 1)) != 0) begin : g_bad_banks
      $error("vmux_switch_ctl: BANKS must be a power of two dividing N_CH");
   end
   if (DEAD_CYC < 1) begin : g_bad_dead
      $error("vmux_switch_ctl: DEAD_CYC must be at least 1");
   end

   vmux_qual_t    qual_in, qual_eff;
   logic [AW-1:0] addr_eff;
   logic          conn;
   logic [AW-1:0] cur_addr;

   assign qual_in = '{en: en_i, cs: cs_i, cs_n: cs_n_i};

   vmux_ctl_latch #(.AW(AW)) u_latch (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .stb_i      (strobe_i),
      .addr_i     (addr_i),
      .qual_i     (qual_in),
      .eff_addr_o (addr_eff),
      .eff_qual_o (qual_eff)
   );

   vmux_bbm_seq #(.AW(AW), .DEAD_CYC(DEAD_CYC)) u_seq (
      .clk_i       (clk_i),
      .rst_i       (rst_i),
      .req_valid_i (vmux_qual_ok(qual_eff)),
      .req_addr_i  (addr_eff),
      .conn_o      (conn),
      .cur_addr_o  (cur_addr)
   );

   vmux_gate_drv #(.N_CH(N_CH), .BANKS(BANKS)) u_drv (
      .conn_i    (conn),
      .sel_i     (cur_addr),
      .ser_in_o  (ser_in_o),
      .ser_out_o (ser_out_o),
      .shunt_o   (shunt_o),
      .bank_o    (bank_o)
   );

   assign act_sink_o = conn;

   // R11
   one_cell_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      $onehot0(ser_in_o) && $onehot0(ser_out_o));

   // R11
   one_bank_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      $onehot0(bank_o));

   // R6
   shunt_excl_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      ((ser_in_o | ser_out_o) & shunt_o) == '0 && (ser_in_o | shunt_o) == '1);

   // R5
   bank_match_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (|ser_in_o) == (|bank_o));

   // R7
   flag_match_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      act_sink_o == (|ser_out_o));

   // R10
   reset_open_chk: assert property (@(posedge clk_i)
      rst_i |=> (!act_sink_o && ser_in_o == '0 && bank_o == '0 && shunt_o == '1));

endmodule

// File: tb/vmux_switch_ctl_tb.sv
module vmux_switch_ctl_tb;

   localparam int N    = 16;
   localparam int NB   = 2;
   localparam int DEAD = 2;
   localparam int AW   = $clog2(N);
   localparam int PER_BANK = N / NB;

   logic clk = 1'b0;
   logic rst, stb, en, cs, cs_n;
   logic [AW-1:0] addr;
   logic [N-1:0]  ser_in, ser_out, shunt;
   logic [NB-1:0] bank;
   logic          sink;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   vmux_switch_ctl #(.N_CH(N), .BANKS(NB), .DEAD_CYC(DEAD)) u_dut (
      .clk_i(clk), .rst_i(rst), .strobe_i(stb), .addr_i(addr),
      .en_i(en), .cs_i(cs), .cs_n_i(cs_n),
      .ser_in_o(ser_in), .ser_out_o(ser_out), .shunt_o(shunt),
      .bank_o(bank), .act_sink_o(sink)
   );

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic drive_ok(input int a);
      addr = AW'(a); en = 1'b1; cs = 1'b1; cs_n = 1'b0;
   endtask

   // ch < 0 means nothing connected
   task automatic expect_ch(input int ch, input string tag);
      logic [N-1:0]  e_ser;
      logic [NB-1:0] e_bank;
      e_ser  = (ch < 0) ? '0 : (N'(1) << ch);
      e_bank = (ch < 0) ? '0 : (NB'(1) << (ch / PER_BANK));
      checks++;
      if (ser_in !== e_ser || ser_out !== e_ser || shunt !== ~e_ser ||
          bank !== e_bank || sink !== (ch >= 0)) begin
         errors++;
         $display("FAIL %s: ser_in=%h ser_out=%h shunt=%h bank=%b sink=%b expected ser=%h shunt=%h bank=%b sink=%b",
                  tag, ser_in, ser_out, shunt, bank, sink, e_ser, ~e_ser, e_bank, (ch >= 0));
      end
   endtask

   // R11 R6 monitor on every cycle
   always @(negedge clk) begin
      if (rst === 1'b0) begin
         checks++;
         if (!$onehot0(ser_in) || !$onehot0(bank) || ser_in !== ser_out || shunt !== ~ser_in) begin
            errors++;
            $display("FAIL R11: ser_in=%h ser_out=%h shunt=%h bank=%b expected at most one closed, shunt complement",
                     ser_in, ser_out, shunt, bank);
         end
      end
   end

   initial begin
      #(4 * 100000);
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      rst = 1'b1; stb = 1'b0; addr = '0; en = 1'b0; cs = 1'b0; cs_n = 1'b1;
      step(3);
      expect_ch(-1, "R10 reset state");
      rst = 1'b0;

      // R1: transparent with strobe high, first connect after one edge
      stb = 1'b1; drive_ok(0);
      step(1); expect_ch(0, "R1 first connect");

      // R4 R5 R6 R7 R9: every address, disable in between
      for (int a = 0; a < N; a++) begin
         en = 1'b0;
         step(1); expect_ch(-1, "R9 disable opens at once");
         drive_ok(a);
         step(1); expect_ch(a, "R4 address map");
      end

      // R3: all qualifier combinations
      drive_ok(5); step(DEAD + 2);
      expect_ch(5, "R8 settle");
      for (int q = 0; q < 8; q++) begin
         en = q[2]; cs = q[1]; cs_n = q[0];
         step(1); expect_ch((q == 6) ? 5 : -1, "R3 qualifier gating");
         drive_ok(5);
         step(1); expect_ch(5, "R3 requalify");
      end

      // R8: cross-bank and same-bank changes
      drive_ok(12);
      for (int k = 0; k < DEAD; k++) begin
         step(1); expect_ch(-1, "R8 gap cross bank");
      end
      step(1); expect_ch(12, "R8 new path cross bank");
      drive_ok(9);
      for (int k = 0; k < DEAD; k++) begin
         step(1); expect_ch(-1, "R8 gap same bank");
      end
      step(1); expect_ch(9, "R8 new path same bank");
      drive_ok(7);
      for (int k = 0; k < DEAD; k++) begin
         step(1); expect_ch(-1, "R8 gap bank boundary");
      end
      step(1); expect_ch(7, "R5 bank boundary");

      // R2: hold while strobe low
      stb = 1'b0; addr = 3; en = 1'b0;
      step(1); expect_ch(7, "R2 hold on strobe fall");
      for (int k = 0; k < 8; k++) begin
         addr = AW'(k * 3); en = k[0]; cs = k[1]; cs_n = k[2];
         step(1); expect_ch(7, "R2 inputs ignored while held");
      end

      // R1: one-cycle strobe pulse latches a new address
      drive_ok(14); stb = 1'b1;
      step(1); expect_ch(-1, "R1 pulse opens old path");
      stb = 1'b0; drive_ok(0);
      step(1); expect_ch(-1, "R8 gap after pulse");
      step(1); expect_ch(14, "R1 latched by pulse");
      step(3); expect_ch(14, "R2 hold after pulse");

      // R9: disable during a gap
      stb = 1'b1; drive_ok(2);
      step(1); expect_ch(-1, "R8 gap start");
      en = 1'b0;
      step(1); expect_ch(-1, "R9 disable in gap");
      en = 1'b1;
      step(1); expect_ch(2, "R9 reconnect without gap");

      // R10: reset clears the held selection
      stb = 1'b0;
      rst = 1'b1;
      step(1); expect_ch(-1, "R10 reset opens");
      rst = 1'b0;
      step(3); expect_ch(-1, "R10 held state cleared");
      stb = 1'b1;
      step(1); expect_ch(2, "R1 after reset");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule